// File: doc/BRIEF.md
# Decode-Stage Hazard Detection and Operand Forwarding

This block sits between decode and execute of a five-stage in-order pipeline with eight architectural registers. It examines the instruction in decode and works out which register it writes. It compares each source operand that the instruction actually reads against a three-slot history of pending destination registers. From the result it records a hazard class and the matching slot of each operand in the decode/execute register. In execute it then picks each operand either from the register-file value captured at decode or from the in-flight result held in the matching history slot.

Slot 0 of the history is the destination of the instruction now in the decode/execute register, which is the youngest. Slots 1 and 2 are older and shift along every cycle. A load whose destination is needed by the very next instruction causes a single stall cycle. During that cycle the dependent instruction is held, its class is cleared, and a bubble flows on into memory. A control flush turns the decode/execute register into a bubble at once.

Top module: `hazard_unit`

## Requirements
- R1: While `rst` is high, and after it is released, the decode/execute register holds a bubble: `ex_op` = 7 (no-op), `ex_dest` = 8, `ex_class` = 0, both hit flags low and `stall` low. All history slots hold 8.
- R2: Opcodes are ADD=0, NAND=1, LW=2, SW=3, BEQ=4, MULT=5, HALT=6 and NOOP=7. ADD, NAND and MULT write `dec_rc`. LW writes `dec_rb`. SW, BEQ, HALT and NOOP give destination code 8, which means no write.
- R3: Slot 0 is the destination currently in the decode/execute register. Slots 1 and 2 are the destinations that left it one and two cycles earlier. An operand's position is the lowest-numbered slot holding its register number. It is reported as a hit flag plus a 2-bit slot index, and the hit flag is low when no slot matches.
- R4: ADD, NAND, SW, BEQ and MULT compare both `dec_ra` and `dec_rb`. LW compares only `dec_ra`. HALT and NOOP compare neither, and an operand that is not compared reports no hit.
- R5: The class codes are 0 = no hazard, 1 = only A matched, 2 = only B matched, 3 = both matched and 4 = load-use.
- R6: When `ex_op` is LW and a compared operand of the decoding instruction matches slot 0, the recorded class is 4. `stall` is high exactly while `ex_class` is 4.
- R7: In a stall cycle the decode/execute register keeps its opcode, destination, positions and values, and its class becomes 0. The history takes in 8 in place of the held destination.
- R8: When the class is 1 or 3, `opnd_a` is the `slot_val` word of the matched slot; otherwise it is the captured `dec_val_a`. `opnd_b` follows the same rule for classes 2 and 3. Slot k occupies bits k*32 and up of `slot_val`.
- R9: When `flush` is high at a clock edge, the decode/execute register becomes the bubble of R1 and the history takes in 8. `flush` takes priority over `stall`.
- R10: When neither a stall nor a flush happens, the history shifts by one slot and takes in the destination leaving the decode/execute register. Code 8 never matches a source register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Control-hazard flush of the decode/execute register |
| dec_op | input | 3 | Opcode of the instruction in decode |
| dec_ra | input | 3 | Register field 0 (source A) |
| dec_rb | input | 3 | Register field 1 (source B, load destination) |
| dec_rc | input | 3 | Low bits of field 2 (arithmetic destination) |
| dec_val_a | input | 32 | Register-file value of source A |
| dec_val_b | input | 32 | Register-file value of source B |
| slot_val | input | 96 | Result values of history slots 0..2, slot k at bits 32k+31:32k |
| stall | output | 1 | Freeze fetch and decode, bubble into memory stage |
| ex_op | output | 3 | Opcode in the decode/execute register |
| ex_class | output | 3 | Recorded hazard class |
| ex_hit_a | output | 1 | Source A matched a slot |
| ex_idx_a | output | 2 | Slot matched by source A |
| ex_hit_b | output | 1 | Source B matched a slot |
| ex_idx_b | output | 2 | Slot matched by source B |
| ex_dest | output | 4 | Destination code (8 = none) |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
The hardest state to reach is a history holding a bubble code in the middle of real destinations. That state only arises after a load-use stall or a flush has pushed 8 in place of a live register. The stimulus first steers a load into execute with a consumer right behind it to force the stall. It then issues an instruction whose operands name both the held destination and the load's register, so the expected slot indices show whether the bubble entered and where the load moved. A flush with a matching instruction in decode is followed by the same kind of probe.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W  = 3;
    localparam int HIST_D = 3;
    localparam int IDX_W  = (HIST_D > 1) ? $clog2(HIST_D) : 1;
    localparam int DEST_W = REG_W + 1;
    localparam logic [DEST_W-1:0] DEST_NONE = DEST_W'(1 << REG_W);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_MULT = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        HC_NONE = 3'd0,
        HC_A    = 3'd1,
        HC_B    = 3'd2,
        HC_AB   = 3'd3,
        HC_LOAD = 3'd4
    } hcls_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_pos_t;

    typedef struct packed {
        op_e               op;
        hcls_e             cls;
        slot_pos_t         pa;
        slot_pos_t         pb;
        logic [DEST_W-1:0] dest;
    } dec_ctl_t;

    localparam dec_ctl_t CTL_BUBBLE = '{op: OP_NOOP, cls: HC_NONE,
                                        pa: '0, pb: '0, dest: DEST_NONE};

    function automatic logic [DEST_W-1:0] dest_for(op_e op, logic [REG_W-1:0] f1,
                                                   logic [REG_W-1:0] f2);
        case (op)
            OP_ADD, OP_NAND, OP_MULT: return {1'b0, f2};
            OP_LW:                    return {1'b0, f1};
            default:                  return DEST_NONE;
        endcase
    endfunction

    function automatic logic reads_a(op_e op);
        return !(op == OP_HALT || op == OP_NOOP);
    endfunction

    function automatic logic reads_b(op_e op);
        return !(op == OP_HALT || op == OP_NOOP || op == OP_LW);
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int DEPTH = HIST_D
) (
    input  logic [REG_W-1:0]              src,
    input  logic [DEPTH-1:0][DEST_W-1:0]  hist,
    output slot_pos_t                     pos
);
    // Scan oldest to youngest so the lowest matching slot wins.
    always_comb begin
        pos = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hist[i] == {1'b0, src}) begin
                pos.hit = 1'b1;
                pos.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/hz_classify.sv
module hz_classify
    import hz_pkg::*;
#(
    parameter int DEPTH = HIST_D
) (
    input  op_e                           op,
    input  logic [REG_W-1:0]              ra,
    input  logic [REG_W-1:0]              rb,
    input  logic [REG_W-1:0]              rc,
    input  logic [DEPTH-1:0][DEST_W-1:0]  hist,
    input  op_e                           ex_op,
    output dec_ctl_t                      ctl
);
    slot_pos_t ma, mb;

    hz_match #(.DEPTH(DEPTH)) u_match_a (.src(ra), .hist(hist), .pos(ma));
    hz_match #(.DEPTH(DEPTH)) u_match_b (.src(rb), .hist(hist), .pos(mb));

    always_comb begin
        ctl      = CTL_BUBBLE;
        ctl.op   = op;
        ctl.dest = dest_for(op, rb, rc);
        ctl.pa   = reads_a(op) ? ma : '0;
        ctl.pb   = reads_b(op) ? mb : '0;
        case ({ctl.pa.hit, ctl.pb.hit})
            2'b11:   ctl.cls = HC_AB;
            2'b10:   ctl.cls = HC_A;
            2'b01:   ctl.cls = HC_B;
            default: ctl.cls = HC_NONE;
        endcase
        if (ex_op == OP_LW &&
            ((ctl.pa.hit && ctl.pa.idx == '0) || (ctl.pb.hit && ctl.pb.idx == '0)))
            ctl.cls = HC_LOAD;
    end
endmodule

// File: rtl/hz_history.sv
module hz_history
    import hz_pkg::*;
#(
    parameter int DEPTH = HIST_D
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DEST_W-1:0]              push,
    output logic [DEPTH-2:0][DEST_W-1:0]   older
);
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                older[g] <= DEST_NONE;
            else if (g == 0)
                older[g] <= push;
            else
                older[g] <= older[(g == 0) ? 0 : g - 1];
        end
    end
endmodule

// File: rtl/hz_fwd_mux.sv
module hz_fwd_mux
    import hz_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = HIST_D
) (
    input  logic                          use_fwd,
    input  slot_pos_t                     pos,
    input  logic [DATA_W-1:0]             reg_val,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slots,
    output logic [DATA_W-1:0]             out
);
    always_comb begin
        out = reg_val;
        for (int i = 0; i < DEPTH; i++)
            if (use_fwd && pos.hit && pos.idx == IDX_W'(i))
                out = slots[i];
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [2:0]               dec_op,
    input  logic [REG_W-1:0]         dec_ra,
    input  logic [REG_W-1:0]         dec_rb,
    input  logic [REG_W-1:0]         dec_rc,
    input  logic [DATA_W-1:0]        dec_val_a,
    input  logic [DATA_W-1:0]        dec_val_b,
    input  logic [HIST_D*DATA_W-1:0] slot_val,
    output logic                     stall,
    output logic [2:0]               ex_op,
    output logic [2:0]               ex_class,
    output logic                     ex_hit_a,
    output logic [IDX_W-1:0]         ex_idx_a,
    output logic                     ex_hit_b,
    output logic [IDX_W-1:0]         ex_idx_b,
    output logic [DEST_W-1:0]        ex_dest,
    output logic [DATA_W-1:0]        opnd_a,
    output logic [DATA_W-1:0]        opnd_b
);
    dec_ctl_t                          ex_q, dec_ctl;
    logic [DATA_W-1:0]                 va_q, vb_q;
    logic [HIST_D-1:0][DEST_W-1:0]     hist;
    logic [HIST_D-2:0][DEST_W-1:0]     older;
    logic [HIST_D-1:0][DATA_W-1:0]     slots;
    logic [DEST_W-1:0]                 push_dest;

    assign hist[0] = ex_q.dest;
    for (genvar g = 1; g < HIST_D; g++) begin : g_hist
        assign hist[g] = older[g-1];
    end
    assign slots = slot_val;

    hz_classify #(.DEPTH(HIST_D)) u_classify (
        .op(op_e'(dec_op)), .ra(dec_ra), .rb(dec_rb), .rc(dec_rc),
        .hist(hist), .ex_op(ex_q.op), .ctl(dec_ctl)
    );

    assign stall     = (ex_q.cls == HC_LOAD);
    assign push_dest = (stall || flush) ? DEST_NONE : ex_q.dest;

    hz_history #(.DEPTH(HIST_D)) u_history (
        .clk(clk), .rst(rst), .push(push_dest), .older(older)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ex_q <= CTL_BUBBLE;
            va_q <= '0;
            vb_q <= '0;
        end else if (stall) begin
            ex_q.cls <= HC_NONE;
        end else begin
            ex_q <= dec_ctl;
            va_q <= dec_val_a;
            vb_q <= dec_val_b;
        end
    end

    hz_fwd_mux #(.DATA_W(DATA_W), .DEPTH(HIST_D)) u_fwd_a (
        .use_fwd(ex_q.cls == HC_A || ex_q.cls == HC_AB), .pos(ex_q.pa),
        .reg_val(va_q), .slots(slots), .out(opnd_a)
    );
    hz_fwd_mux #(.DATA_W(DATA_W), .DEPTH(HIST_D)) u_fwd_b (
        .use_fwd(ex_q.cls == HC_B || ex_q.cls == HC_AB), .pos(ex_q.pb),
        .reg_val(vb_q), .slots(slots), .out(opnd_b)
    );

    assign ex_op    = ex_q.op;
    assign ex_class = ex_q.cls;
    assign ex_hit_a = ex_q.pa.hit;
    assign ex_idx_a = ex_q.pa.idx;
    assign ex_hit_b = ex_q.pb.hit;
    assign ex_idx_b = ex_q.pb.idx;
    assign ex_dest  = ex_q.dest;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       stall,
    input logic [2:0] ex_op,
    input logic [2:0] ex_class,
    input logic       ex_hit_a,
    input logic [1:0] ex_idx_a,
    input logic       ex_hit_b,
    input logic [1:0] ex_idx_b,
    input logic [3:0] ex_dest
);
    a_r7_hold_clears: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> (ex_class == 3'd0 && $stable(ex_op) && $stable(ex_dest)));

    a_r9_flush_bubble: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ex_op == 3'd7 && ex_dest == 4'd8 && !ex_hit_a && !ex_hit_b && ex_class == 3'd0));

    a_r6_single_stall: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    a_r6_load_slot0: assert property (@(posedge clk) disable iff (rst)
        (ex_class == 3'd4) |-> ((ex_hit_a && ex_idx_a == 2'd0) || (ex_hit_b && ex_idx_b == 2'd0)));

    a_r5_both: assert property (@(posedge clk) disable iff (rst)
        (ex_class == 3'd3) |-> (ex_hit_a && ex_hit_b));

    a_r5_only_a: assert property (@(posedge clk) disable iff (rst)
        (ex_class == 3'd1) |-> (ex_hit_a && !ex_hit_b));

    a_r5_only_b: assert property (@(posedge clk) disable iff (rst)
        (ex_class == 3'd2) |-> (!ex_hit_a && ex_hit_b));

    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        ((ex_hit_a -> ex_idx_a < 2'd3) && (ex_hit_b -> ex_idx_b < 2'd3)));

    a_r2_no_write: assert property (@(posedge clk) disable iff (rst)
        (ex_op == 3'd3 || ex_op == 3'd4 || ex_op == 3'd6 || ex_op == 3'd7) |-> ex_dest == 4'd8);

    a_r2_writes: assert property (@(posedge clk) disable iff (rst)
        (ex_op == 3'd0 || ex_op == 3'd1 || ex_op == 3'd2 || ex_op == 3'd5) |-> ex_dest < 4'd8);
endmodule

bind hazard_unit hazard_unit_chk u_chk (
    .clk(clk), .rst(rst), .flush(flush), .stall(stall), .ex_op(ex_op),
    .ex_class(ex_class), .ex_hit_a(ex_hit_a), .ex_idx_a(ex_idx_a),
    .ex_hit_b(ex_hit_b), .ex_idx_b(ex_idx_b), .ex_dest(ex_dest)
);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [2:0]  dec_op = 3'd7, dec_ra = '0, dec_rb = '0, dec_rc = '0;
    logic [31:0] dec_val_a = '0, dec_val_b = '0;
    logic [95:0] slot_val;
    logic        stall, ex_hit_a, ex_hit_b;
    logic [2:0]  ex_op, ex_class;
    logic [1:0]  ex_idx_a, ex_idx_b;
    logic [3:0]  ex_dest;
    logic [31:0] opnd_a, opnd_b;
    int          n_checks = 0, n_err = 0;
    bit          done = 0;

    localparam logic [31:0] SV0 = 32'hAAAA_0000, SV1 = 32'hBBBB_1111, SV2 = 32'hCCCC_2222;
    assign slot_val = {SV2, SV1, SV0};

    always #2 clk = ~clk;

    hazard_unit i_hazard_unit (
        .clk(clk), .rst(rst), .flush(flush), .dec_op(dec_op), .dec_ra(dec_ra),
        .dec_rb(dec_rb), .dec_rc(dec_rc), .dec_val_a(dec_val_a), .dec_val_b(dec_val_b),
        .slot_val(slot_val), .stall(stall), .ex_op(ex_op), .ex_class(ex_class),
        .ex_hit_a(ex_hit_a), .ex_idx_a(ex_idx_a), .ex_hit_b(ex_hit_b), .ex_idx_b(ex_idx_b),
        .ex_dest(ex_dest), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    typedef struct packed {
        logic [2:0] op, a, b, c;
        logic [2:0] cls;
        logic [3:0] dest;
        logic       ha;
        logic [1:0] ia;
        logic       hb;
        logic [1:0] ib;
    } vec_t;

    // Sequence from reset; expected history tracked by hand per R3/R10.
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 4'd3, 1'b0, 2'd0, 1'b0, 2'd0}, // ADD, no match
        '{3'd1, 3'd3, 3'd4, 3'd5, 3'd1, 4'd5, 1'b1, 2'd0, 1'b0, 2'd0}, // NAND A@0
        '{3'd5, 3'd1, 3'd3, 3'd6, 3'd2, 4'd6, 1'b0, 2'd0, 1'b1, 2'd1}, // MULT B@1
        '{3'd3, 3'd3, 3'd6, 3'd7, 3'd3, 4'd8, 1'b1, 2'd2, 1'b1, 2'd0}, // SW A@2 B@0
        '{3'd4, 3'd5, 3'd5, 3'd1, 3'd3, 4'd8, 1'b1, 2'd2, 1'b1, 2'd2}, // BEQ both @2
        '{3'd2, 3'd1, 3'd6, 3'd0, 3'd0, 4'd6, 1'b0, 2'd0, 1'b0, 2'd0}, // LW, B unchecked
        '{3'd6, 3'd6, 3'd6, 3'd0, 3'd0, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0}, // HALT checks none
        '{3'd7, 3'd6, 3'd6, 3'd0, 3'd0, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0}, // NOOP checks none
        '{3'd0, 3'd6, 3'd6, 3'd6, 3'd3, 4'd6, 1'b1, 2'd2, 1'b1, 2'd2}, // ADD both @2
        '{3'd0, 3'd6, 3'd0, 3'd1, 3'd1, 4'd1, 1'b1, 2'd0, 1'b0, 2'd0}, // ADD A@0
        '{3'd0, 3'd1, 3'd6, 3'd2, 3'd3, 4'd2, 1'b1, 2'd0, 1'b1, 2'd1}, // ADD A@0 B@1
        '{3'd0, 3'd7, 3'd7, 3'd2, 3'd0, 4'd2, 1'b0, 2'd0, 1'b0, 2'd0}, // ADD no match
        '{3'd1, 3'd2, 3'd1, 3'd0, 3'd3, 4'd0, 1'b1, 2'd0, 1'b1, 2'd2}  // NAND dup: first slot wins
    };

    function automatic logic [31:0] slotv(logic [1:0] i);
        return (i == 2'd0) ? SV0 : (i == 2'd1) ? SV1 : SV2;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, step one rising edge, return at the next falling edge.
    task automatic issue(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] c,
                         logic [31:0] va, logic [31:0] vb, logic fl);
        dec_op = op; dec_ra = a; dec_rb = b; dec_rc = c;
        dec_val_a = va; dec_val_b = vb; flush = fl;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic chk_ctl(string req, logic [2:0] cls, logic [3:0] dest, logic ha,
                           logic [1:0] ia, logic hb, logic [1:0] ib);
        chk({req, " class"}, 32'(ex_class), 32'(cls));
        chk({req, " dest"}, 32'(ex_dest), 32'(dest));
        chk({req, " hit_a"}, 32'(ex_hit_a), 32'(ha));
        if (ha) chk({req, " idx_a"}, 32'(ex_idx_a), 32'(ia));
        chk({req, " hit_b"}, 32'(ex_hit_b), 32'(hb));
        if (hb) chk({req, " idx_b"}, 32'(ex_idx_b), 32'(ib));
    endtask

    task automatic chk_reset();
        chk("R1 stall", 32'(stall), 32'd0);
        chk("R1 op", 32'(ex_op), 32'd7);
        chk_ctl("R1", 3'd0, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_reset();
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk_reset();

        // Table walk: R2 R3 R4 R5 R8 R10
        for (int i = 0; i < NV; i++) begin
            logic [31:0] ea, eb, va, vb;
            va = 32'h100 + 32'(i);
            vb = 32'h200 + 32'(i);
            issue(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].c, va, vb, 1'b0);
            chk_ctl($sformatf("R3/R4/R5 vec%0d", i), TBL[i].cls, TBL[i].dest,
                    TBL[i].ha, TBL[i].ia, TBL[i].hb, TBL[i].ib);
            chk("R2 op", 32'(ex_op), 32'(TBL[i].op));
            ea = (TBL[i].cls == 3'd1 || TBL[i].cls == 3'd3) ? slotv(TBL[i].ia) : va;
            eb = (TBL[i].cls == 3'd2 || TBL[i].cls == 3'd3) ? slotv(TBL[i].ib) : vb;
            chk("R8 opnd_a", opnd_a, ea);
            chk("R8 opnd_b", opnd_b, eb);
        end

        // Load-use on operand A (R6, R7)
        do_reset();
        issue(3'd2, 3'd0, 3'd4, 3'd0, 32'h1, 32'h2, 1'b0);
        chk_ctl("R2 lw dest", 3'd0, 4'd4, 1'b0, 2'd0, 1'b0, 2'd0);
        issue(3'd0, 3'd4, 3'd0, 3'd5, 32'h11, 32'h22, 1'b0);
        chk_ctl("R6 load-use A", 3'd4, 4'd5, 1'b1, 2'd0, 1'b0, 2'd0);
        chk("R6 stall", 32'(stall), 32'd1);
        issue(3'd1, 3'd7, 3'd7, 3'd7, 32'h99, 32'h98, 1'b0);
        chk("R7 held op", 32'(ex_op), 32'd0);
        chk_ctl("R7 held", 3'd0, 4'd5, 1'b1, 2'd0, 1'b0, 2'd0);
        chk("R7 stall released", 32'(stall), 32'd0);
        chk("R8 class 0 uses register value", opnd_a, 32'h11);
        issue(3'd1, 3'd4, 3'd5, 3'd1, 32'h0, 32'h0, 1'b0);
        chk_ctl("R7 bubble pushed", 3'd3, 4'd1, 1'b1, 2'd2, 1'b1, 2'd0);

        // Load-use on operand B (R6)
        issue(3'd2, 3'd0, 3'd3, 3'd0, 32'h0, 32'h0, 1'b0);
        chk_ctl("R6 lw", 3'd0, 4'd3, 1'b0, 2'd0, 1'b0, 2'd0);
        issue(3'd5, 3'd0, 3'd3, 3'd2, 32'h0, 32'h0, 1'b0);
        chk_ctl("R6 load-use B", 3'd4, 4'd2, 1'b0, 2'd0, 1'b1, 2'd0);
        chk("R6 stall B", 32'(stall), 32'd1);
        issue(3'd7, 3'd0, 3'd0, 3'd0, 32'h0, 32'h0, 1'b0);
        chk("R7 release", 32'(stall), 32'd0);

        // Load in execute, consumer that checks nothing (R4, R6)
        issue(3'd2, 3'd7, 3'd6, 3'd0, 32'h0, 32'h0, 1'b0);
        issue(3'd6, 3'd6, 3'd6, 3'd0, 32'h0, 32'h0, 1'b0);
        chk("R6 halt no stall", 32'(stall), 32'd0);
        chk_ctl("R4 halt", 3'd0, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0);

        // Load in execute, match only in an older slot (R6)
        issue(3'd2, 3'd0, 3'd4, 3'd0, 32'h0, 32'h0, 1'b0);
        issue(3'd0, 3'd6, 3'd0, 3'd3, 32'h0, 32'h0, 1'b0);
        chk_ctl("R6 older slot", 3'd1, 4'd3, 1'b1, 2'd2, 1'b0, 2'd0);
        chk("R6 older no stall", 32'(stall), 32'd0);
        chk("R8 slot2 forward", opnd_a, SV2);

        // Flush (R9): destination 3 in execute is discarded
        issue(3'd0, 3'd3, 3'd3, 3'd1, 32'h0, 32'h0, 1'b1);
        chk("R9 op", 32'(ex_op), 32'd7);
        chk_ctl("R9 flush", 3'd0, 4'd8, 1'b0, 2'd0, 1'b0, 2'd0);
        issue(3'd0, 3'd3, 3'd4, 3'd0, 32'h0, 32'h0, 1'b0);
        chk_ctl("R9 history after flush", 3'd2, 4'd0, 1'b0, 2'd0, 1'b1, 2'd2);

        // Mid-run reset (R1)
        do_reset();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule